// File: doc/BRIEF.md
# PCI Function Configuration Header

This block holds the 256-byte type-0 configuration header of a single PCI function. A bus protocol engine, outside the block, presents each configuration access as a 6-bit dword index, four byte enables and a write strobe. Reads return the addressed dword combinationally. Writes take effect on the next rising clock edge.

The header carries read-only identification, a command register and a status register, and three base address registers of fixed type and size: a 256-byte I/O window, a 1 KB 64-bit memory window and a 64 KB 64-bit memory window. It also carries an expansion ROM base register and a capability chain. The chain links power management to message-signalled interrupts. From this state the block decodes the enables that the target and master logic consume, the window bases, the power state, and the MSI address and data.

In power state D2 the I/O, memory and bus-master enables and the legacy interrupt output are all held off. The stored command bits are kept, so they take effect again when the function returns to D0.

Top module: `cfg_space`

## Requirements
- R1: After reset, the command register reads 0 and every decoded enable, base output and the power state are 0. The I/O BAR reads 0x00000001, both memory BAR low dwords read 0x00000004, and the ROM BAR reads 0.
- R2: Dword 0 reads {DEVICE_ID, VENDOR_ID} and dword 2 reads {24'h010000, REV_ID}. Writes to either dword change nothing.
- R3: Each byte enable bit n gates write lane n (bits 8n+7:8n). A write with all byte enables clear changes no register and no output. Reserved and read-only bits ignore writes.
- R4: In the I/O BAR (dword 4), bits 31:8 are writable, bit 0 reads 1 and bits 7:1 read 0, so writing all ones reads back 0xFFFFFF01. io_base_o equals the writable bits with the low byte cleared.
- R5: In memory BAR 0 (low dword 5, high dword 6), low bits 31:10 are writable and low bits 3:0 read 0x4 (64-bit, non-prefetchable). The high dword is fully writable. All ones reads back 0xFFFFFC04, and mem0_base_o = {high, low with bits 9:0 cleared}.
- R6: In memory BAR 1 (low dword 7, high dword 8), low bits 31:16 are writable with the same type bits, so all ones reads back 0xFFFF0004. mem1_base_o is formed the same way as mem0_base_o.
- R7: In the ROM BAR (dword 12), bits 31:11 and enable bit 0 are writable, so all ones reads back 0xFFFFF801. rom_en_o is 1 only when bit 0 is set and the effective memory enable is on.
- R8: Command bits 0, 1, 2, 6, 8 and 10 are writable; all other command bits read 0. Status (dword 1 bits 31:16) reads 0x0010. Command bits 0, 1 and 2 drive io_en_o, mem_en_o and bus_master_o.
- R9: Until the latency timer (dword 3 bits 15:8) is written, it reads 0x00 when pcix_mode_i is 0 and 0x40 when pcix_mode_i is 1. Once written, it reads the written value. The cache line size (bits 7:0) is a plain read/write byte.
- R10: Power state is held in dword 17 bits 1:0. In D2 (2'b10), io_en_o, mem_en_o, bus_master_o, rom_en_o and intx_o are forced to 0 while the command readback is unchanged. After a return to D0 the stored enables apply again. intx_o = core_irq_i when not in D2, command bit 10 is clear and MSI is disabled.
- R11: Dword 13 reads 0x40. Dword 16 reads capability ID 0x01 with next pointer 0x48 (value 0x00024801). Dword 18 bits 15:0 read capability ID 0x05 with next pointer 0x00.
- R12: In dword 18, bit 16 is the MSI enable. Bits 19:17 read the messages-capable exponent MSI_MMC. Bits 22:20 are the allocated exponent, and a write larger than MSI_MMC stores MSI_MMC, which keeps the count a power of two no larger than capable. Bit 23 reads 1.
- R13: The MSI address is formed from dword 19 bits 31:2 (bits 1:0 read 0) and dword 20. The MSI data comes from dword 21 bits 15:0. These drive msi_addr_o and msi_data_o, and msi_en_o follows bit 16 of dword 18. Dwords with no register read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pcix_mode_i | input | 1 | Bus runs in PCI-X mode |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_idx_i | input | 6 | Dword index of the access |
| cfg_be_i | input | 4 | Byte enables of the write |
| cfg_wdata_i | input | 32 | Write data |
| cfg_rdata_o | output | 32 | Read data for cfg_idx_i |
| core_irq_i | input | 1 | Interrupt request from the function core |
| intx_o | output | 1 | Gated legacy interrupt |
| io_en_o | output | 1 | I/O decode enable |
| mem_en_o | output | 1 | Memory decode enable |
| bus_master_o | output | 1 | Bus master enable |
| rom_en_o | output | 1 | Expansion ROM decode enable |
| io_base_o | output | 32 | I/O window base |
| mem0_base_o | output | 64 | Memory window 0 base |
| mem1_base_o | output | 64 | Memory window 1 base |
| rom_base_o | output | 32 | Expansion ROM base |
| pwr_state_o | output | 2 | Current power state |
| msi_en_o | output | 1 | MSI enabled |
| msi_addr_o | output | 64 | MSI message address |
| msi_data_o | output | 16 | MSI message data |

## Verification
The assertions check the following on every cycle:
- D2 keeps all enables and the legacy interrupt off.
- ROM decode never runs without memory decode.
- MSI enable blocks the legacy interrupt.
- The allocated MSI exponent never exceeds the capable one.
- Cycles without a write, or with no byte enabled, leave every decoded output unchanged.

The bench scenarios cover what needs a history of accesses:
- sizing readbacks after all-ones writes, and per-lane masking under random byte enables;
- the latency-timer default switching with the bus mode until the first write;
- command enables resuming after a D2 to D0 round trip;
- the clamping of oversize MSI allocations.

// File: rtl/cfg_space_pkg.sv
package cfg_space_pkg;
  typedef logic [5:0] idx_t;
  localparam idx_t IDX_ID     = 6'd0;
  localparam idx_t IDX_CMD    = 6'd1;
  localparam idx_t IDX_CLASS  = 6'd2;
  localparam idx_t IDX_MISC   = 6'd3;
  localparam idx_t IDX_IOBAR  = 6'd4;
  localparam idx_t IDX_M0LO   = 6'd5;
  localparam idx_t IDX_M0HI   = 6'd6;
  localparam idx_t IDX_M1LO   = 6'd7;
  localparam idx_t IDX_M1HI   = 6'd8;
  localparam idx_t IDX_SUBSYS = 6'd11;
  localparam idx_t IDX_ROM    = 6'd12;
  localparam idx_t IDX_CAPP   = 6'd13;
  localparam idx_t IDX_INT    = 6'd15;
  localparam idx_t IDX_PM     = 6'd16;
  localparam idx_t IDX_PMCSR  = 6'd17;
  localparam idx_t IDX_MSI    = 6'd18;
  localparam idx_t IDX_MALO   = 6'd19;
  localparam idx_t IDX_MAHI   = 6'd20;
  localparam idx_t IDX_MDATA  = 6'd21;

  typedef enum logic [1:0] {PS_D0 = 2'b00, PS_D1 = 2'b01, PS_D2 = 2'b10, PS_D3 = 2'b11} pstate_e;

  // byte-lane write merge restricted to writable bits
  function automatic logic [31:0] lane_merge(input logic [31:0] old_v, input logic [31:0] wr_v,
                                             input logic [3:0] be, input logic [31:0] wmask);
    logic [31:0] r;
    r = old_v;
    for (int b = 0; b < 4; b++)
      if (be[b]) r[8*b +: 8] = (old_v[8*b +: 8] & ~wmask[8*b +: 8]) | (wr_v[8*b +: 8] & wmask[8*b +: 8]);
    return r;
  endfunction
endpackage

// File: rtl/cfg_bar.sv
module cfg_bar
  import cfg_space_pkg::*;
#(
  parameter int unsigned SIZE_LOG2 = 8,
  parameter bit          IS_IO     = 1'b0,
  parameter bit          WIDE      = 1'b1,
  localparam int unsigned BW       = WIDE ? 64 : 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_lo_i,
  input  logic          we_hi_i,
  input  logic [3:0]    be_i,
  input  logic [31:0]   wdata_i,
  output logic [31:0]   rd_lo_o,
  output logic [BW-1:0] base_o
);
  localparam logic [31:0] LO_MASK   = ~((32'd1 << SIZE_LOG2) - 32'd1);
  localparam logic [31:0] TYPE_BITS = IS_IO ? 32'h1 : (WIDE ? 32'h4 : 32'h0);

  logic [31:0] lo_q;
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)      lo_q <= '0;
    else if (we_lo_i) lo_q <= lane_merge(lo_q, wdata_i, be_i, LO_MASK);

  assign rd_lo_o = lo_q | TYPE_BITS;

  generate
    if (WIDE) begin : g_wide
      logic [31:0] hi_q;
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni)      hi_q <= '0;
        else if (we_hi_i) hi_q <= lane_merge(hi_q, wdata_i, be_i, 32'hFFFF_FFFF);
      assign base_o = {hi_q, lo_q};
    end else begin : g_narrow
      logic unused_hi;
      assign unused_hi = we_hi_i;
      assign base_o    = lo_q;
    end
  endgenerate
endmodule

// File: rtl/cfg_msi.sv
module cfg_msi
  import cfg_space_pkg::*;
#(
  parameter int unsigned MSI_MMC = 3
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        we_ctl_i,
  input  logic        we_alo_i,
  input  logic        we_ahi_i,
  input  logic        we_dat_i,
  input  logic [3:0]  be_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] ctl_rd_o,
  output logic [31:0] alo_rd_o,
  output logic [31:0] ahi_rd_o,
  output logic [31:0] dat_rd_o,
  output logic        msi_en_o,
  output logic [63:0] msi_addr_o,
  output logic [15:0] msi_data_o
);
  localparam logic [2:0] MMC = 3'(MSI_MMC);

  logic        en_q;
  logic [2:0]  mme_q, mme_req;
  logic [31:0] alo_q, ahi_q, dat_q;

  assign mme_req = wdata_i[22:20];

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      en_q  <= 1'b0;
      mme_q <= '0;
      alo_q <= '0;
      ahi_q <= '0;
      dat_q <= '0;
    end else begin
      if (we_ctl_i && be_i[2]) begin
        en_q  <= wdata_i[16];
        mme_q <= (mme_req > MMC) ? MMC : mme_req;  // keep allocation within capability
      end
      if (we_alo_i) alo_q <= lane_merge(alo_q, wdata_i, be_i, 32'hFFFF_FFFC);
      if (we_ahi_i) ahi_q <= lane_merge(ahi_q, wdata_i, be_i, 32'hFFFF_FFFF);
      if (we_dat_i) dat_q <= lane_merge(dat_q, wdata_i, be_i, 32'h0000_FFFF);
    end

  assign ctl_rd_o   = {8'h00, 1'b1, mme_q, MMC, en_q, 8'h00, 8'h05};
  assign alo_rd_o   = alo_q;
  assign ahi_rd_o   = ahi_q;
  assign dat_rd_o   = dat_q;
  assign msi_en_o   = en_q;
  assign msi_addr_o = {ahi_q, alo_q};
  assign msi_data_o = dat_q[15:0];
endmodule

// File: rtl/cfg_space.sv
module cfg_space
  import cfg_space_pkg::*;
#(
  parameter logic [15:0] VENDOR_ID  = 16'hABCD,
  parameter logic [15:0] DEVICE_ID  = 16'h0030,
  parameter logic [7:0]  REV_ID     = 8'h01,
  parameter logic [15:0] SUBSYS_VID = 16'h0000,
  parameter logic [15:0] SUBSYS_ID  = 16'h0000,
  parameter logic [7:0]  LAT_PCIX   = 8'h40,
  parameter int unsigned IO_LOG2    = 8,
  parameter int unsigned M0_LOG2    = 10,
  parameter int unsigned M1_LOG2    = 16,
  parameter int unsigned MSI_MMC    = 3
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        pcix_mode_i,
  input  logic        cfg_we_i,
  input  logic [5:0]  cfg_idx_i,
  input  logic [3:0]  cfg_be_i,
  input  logic [31:0] cfg_wdata_i,
  output logic [31:0] cfg_rdata_o,
  input  logic        core_irq_i,
  output logic        intx_o,
  output logic        io_en_o,
  output logic        mem_en_o,
  output logic        bus_master_o,
  output logic        rom_en_o,
  output logic [31:0] io_base_o,
  output logic [63:0] mem0_base_o,
  output logic [63:0] mem1_base_o,
  output logic [31:0] rom_base_o,
  output logic [1:0]  pwr_state_o,
  output logic        msi_en_o,
  output logic [63:0] msi_addr_o,
  output logic [15:0] msi_data_o
);
  localparam logic [31:0] CMD_WMASK = 32'h0000_0547;
  localparam logic [31:0] ROM_WMASK = 32'hFFFF_F801;

  logic [31:0] cmd_q, misc_q, rom_q, int_q, pm_q;
  logic        lat_set_q;
  logic [7:0]  lat_rd;
  logic        in_d2;

  function automatic logic hit(input idx_t i);
    return cfg_we_i && (cfg_idx_i == i);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      cmd_q     <= '0;
      misc_q    <= '0;
      rom_q     <= '0;
      int_q     <= '0;
      pm_q      <= '0;
      lat_set_q <= 1'b0;
    end else begin
      if (hit(IDX_CMD))   cmd_q  <= lane_merge(cmd_q, cfg_wdata_i, cfg_be_i, CMD_WMASK);
      if (hit(IDX_MISC))  misc_q <= lane_merge(misc_q, cfg_wdata_i, cfg_be_i, 32'h0000_FFFF);
      if (hit(IDX_MISC) && cfg_be_i[1]) lat_set_q <= 1'b1;
      if (hit(IDX_ROM))   rom_q  <= lane_merge(rom_q, cfg_wdata_i, cfg_be_i, ROM_WMASK);
      if (hit(IDX_INT))   int_q  <= lane_merge(int_q, cfg_wdata_i, cfg_be_i, 32'h0000_00FF);
      if (hit(IDX_PMCSR)) pm_q   <= lane_merge(pm_q, cfg_wdata_i, cfg_be_i, 32'h0000_0003);
    end

  // the latency timer follows the bus mode until software writes it
  assign lat_rd = lat_set_q ? misc_q[15:8] : (pcix_mode_i ? LAT_PCIX : 8'h00);

  logic [31:0] io_rd, m0_rd, m1_rd;
  logic [31:0] io_base;

  cfg_bar #(.SIZE_LOG2(IO_LOG2), .IS_IO(1'b1), .WIDE(1'b0)) u_bar_io (
    .clk_i, .rst_ni, .we_lo_i(hit(IDX_IOBAR)), .we_hi_i(1'b0), .be_i(cfg_be_i),
    .wdata_i(cfg_wdata_i), .rd_lo_o(io_rd), .base_o(io_base));

  cfg_bar #(.SIZE_LOG2(M0_LOG2), .IS_IO(1'b0), .WIDE(1'b1)) u_bar_m0 (
    .clk_i, .rst_ni, .we_lo_i(hit(IDX_M0LO)), .we_hi_i(hit(IDX_M0HI)), .be_i(cfg_be_i),
    .wdata_i(cfg_wdata_i), .rd_lo_o(m0_rd), .base_o(mem0_base_o));

  cfg_bar #(.SIZE_LOG2(M1_LOG2), .IS_IO(1'b0), .WIDE(1'b1)) u_bar_m1 (
    .clk_i, .rst_ni, .we_lo_i(hit(IDX_M1LO)), .we_hi_i(hit(IDX_M1HI)), .be_i(cfg_be_i),
    .wdata_i(cfg_wdata_i), .rd_lo_o(m1_rd), .base_o(mem1_base_o));

  logic [31:0] msi_ctl_rd, msi_alo_rd, msi_ahi_rd, msi_dat_rd;

  cfg_msi #(.MSI_MMC(MSI_MMC)) u_msi (
    .clk_i, .rst_ni,
    .we_ctl_i(hit(IDX_MSI)), .we_alo_i(hit(IDX_MALO)), .we_ahi_i(hit(IDX_MAHI)),
    .we_dat_i(hit(IDX_MDATA)), .be_i(cfg_be_i), .wdata_i(cfg_wdata_i),
    .ctl_rd_o(msi_ctl_rd), .alo_rd_o(msi_alo_rd), .ahi_rd_o(msi_ahi_rd), .dat_rd_o(msi_dat_rd),
    .msi_en_o, .msi_addr_o, .msi_data_o);

  always_comb begin
    unique case (cfg_idx_i)
      IDX_ID:     cfg_rdata_o = {DEVICE_ID, VENDOR_ID};
      IDX_CMD:    cfg_rdata_o = cmd_q | 32'h0010_0000;
      IDX_CLASS:  cfg_rdata_o = {24'h010000, REV_ID};
      IDX_MISC:   cfg_rdata_o = {misc_q[31:16], lat_rd, misc_q[7:0]};
      IDX_IOBAR:  cfg_rdata_o = io_rd;
      IDX_M0LO:   cfg_rdata_o = m0_rd;
      IDX_M0HI:   cfg_rdata_o = mem0_base_o[63:32];
      IDX_M1LO:   cfg_rdata_o = m1_rd;
      IDX_M1HI:   cfg_rdata_o = mem1_base_o[63:32];
      IDX_SUBSYS: cfg_rdata_o = {SUBSYS_ID, SUBSYS_VID};
      IDX_ROM:    cfg_rdata_o = rom_q;
      IDX_CAPP:   cfg_rdata_o = 32'h0000_0040;
      IDX_INT:    cfg_rdata_o = int_q | 32'h0010_0100;
      IDX_PM:     cfg_rdata_o = 32'h0002_4801;
      IDX_PMCSR:  cfg_rdata_o = pm_q;
      IDX_MSI:    cfg_rdata_o = msi_ctl_rd;
      IDX_MALO:   cfg_rdata_o = msi_alo_rd;
      IDX_MAHI:   cfg_rdata_o = msi_ahi_rd;
      IDX_MDATA:  cfg_rdata_o = msi_dat_rd;
      default:    cfg_rdata_o = '0;
    endcase
  end

  assign pwr_state_o  = pm_q[1:0];
  assign in_d2        = (pstate_e'(pm_q[1:0]) == PS_D2);
  assign io_en_o      = cmd_q[0] & ~in_d2;
  assign mem_en_o     = cmd_q[1] & ~in_d2;
  assign bus_master_o = cmd_q[2] & ~in_d2;
  assign rom_en_o     = rom_q[0] & mem_en_o;
  assign intx_o       = core_irq_i & ~in_d2 & ~cmd_q[10] & ~msi_en_o;
  assign io_base_o    = io_base;
  assign rom_base_o   = {rom_q[31:11], 11'b0};
endmodule

// File: rtl/cfg_space_chk.sv
module cfg_space_chk #(
  parameter int unsigned MSI_MMC = 3
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        cfg_we_i,
  input logic [5:0]  cfg_idx_i,
  input logic [3:0]  cfg_be_i,
  input logic [31:0] cfg_rdata_o,
  input logic        intx_o,
  input logic        io_en_o,
  input logic        mem_en_o,
  input logic        bus_master_o,
  input logic        rom_en_o,
  input logic [31:0] io_base_o,
  input logic [63:0] mem0_base_o,
  input logic [63:0] mem1_base_o,
  input logic [31:0] rom_base_o,
  input logic [1:0]  pwr_state_o,
  input logic        msi_en_o,
  input logic [63:0] msi_addr_o,
  input logic [15:0] msi_data_o
);
  AST_D2_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_state_o == 2'b10 |-> !io_en_o && !mem_en_o && !bus_master_o && !rom_en_o && !intx_o); // R10
  AST_ROM_NEEDS_MEM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rom_en_o |-> mem_en_o); // R7
  AST_MSI_BLOCKS_INTX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msi_en_o |-> !intx_o); // R13
  AST_MME_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_idx_i == 6'd18 |-> cfg_rdata_o[22:20] <= 3'(MSI_MMC)); // R12
  AST_IDLE_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_we_i || cfg_be_i == 4'b0000) |=> $stable(io_base_o) && $stable(mem0_base_o) &&
      $stable(mem1_base_o) && $stable(rom_base_o) && $stable(pwr_state_o) &&
      $stable(msi_addr_o) && $stable(msi_data_o) && $stable(msi_en_o)); // R3
endmodule

bind cfg_space cfg_space_chk #(.MSI_MMC(MSI_MMC)) u_chk (.*);

// File: tb/sim_cfg_space.sv
module sim_cfg_space;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        pcix = 1'b0, we = 1'b0, irq = 1'b0;
  logic [5:0]  idx = '0;
  logic [3:0]  be = '0;
  logic [31:0] wdata = '0, rdata;
  logic        intx, io_en, mem_en, bm, rom_en, msi_en;
  logic [31:0] io_base, rom_base;
  logic [63:0] m0_base, m1_base, msi_addr;
  logic [1:0]  pwr;
  logic [15:0] msi_data;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  cfg_space u0 (
    .clk_i(clk), .rst_ni(rst_n), .pcix_mode_i(pcix), .cfg_we_i(we), .cfg_idx_i(idx),
    .cfg_be_i(be), .cfg_wdata_i(wdata), .cfg_rdata_o(rdata), .core_irq_i(irq), .intx_o(intx),
    .io_en_o(io_en), .mem_en_o(mem_en), .bus_master_o(bm), .rom_en_o(rom_en),
    .io_base_o(io_base), .mem0_base_o(m0_base), .mem1_base_o(m1_base), .rom_base_o(rom_base),
    .pwr_state_o(pwr), .msi_en_o(msi_en), .msi_addr_o(msi_addr), .msi_data_o(msi_data));

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] i, input logic [3:0] b, input logic [31:0] d);
    @(negedge clk); we = 1'b1; idx = i; be = b; wdata = d;
    @(negedge clk); we = 1'b0; be = '0;
  endtask

  task automatic rd(input logic [5:0] i, output logic [31:0] d);
    @(negedge clk); we = 1'b0; idx = i; #1; d = rdata;
  endtask

  function automatic logic [31:0] wmask(input logic [5:0] i);
    case (i)
      6'd4: return 32'hFFFF_FF00;
      6'd5: return 32'hFFFF_FC00;
      6'd7: return 32'hFFFF_0000;
      default: return 32'hFFFF_F801;
    endcase
  endfunction

  function automatic logic [31:0] tbits(input logic [5:0] i);
    case (i)
      6'd4: return 32'h1;
      6'd5, 6'd7: return 32'h4;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] merge(input logic [31:0] o, input logic [31:0] d,
                                        input logic [3:0] b, input logic [31:0] m);
    logic [31:0] r = o;
    for (int k = 0; k < 4; k++) if (b[k]) r[8*k +: 8] = (o[8*k +: 8] & ~m[8*k +: 8]) | (d[8*k +: 8] & m[8*k +: 8]);
    return r;
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    logic [31:0] sh [4];
    logic [5:0] ids [4];
    void'($urandom(32'd1234));
    ids[0] = 6'd4; ids[1] = 6'd5; ids[2] = 6'd7; ids[3] = 6'd12;
    for (int k = 0; k < 4; k++) sh[k] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(6'd1, r);  chk("R1 cmd", r, 32'h0010_0000);
    chk("R1 enables", {io_en, mem_en, bm, rom_en, msi_en, pwr}, 0);
    chk("R1 bases", io_base | m0_base | m1_base | rom_base, 0);
    rd(6'd4, r);  chk("R1 iobar", r, 32'h1);
    rd(6'd5, r);  chk("R1 m0lo", r, 32'h4);
    rd(6'd7, r);  chk("R1 m1lo", r, 32'h4);
    rd(6'd12, r); chk("R1 rom", r, 0);
    rd(6'd3, r);  chk("R9 lat conv", r, 0);

    // R2 identification
    wr(6'd0, 4'hF, 32'hFFFF_FFFF); rd(6'd0, r); chk("R2 id", r, 32'h0030_ABCD);
    wr(6'd2, 4'hF, 32'h0); rd(6'd2, r); chk("R2 class", r, 32'h0100_0001);

    // R11 capability chain, R13 unused dword
    rd(6'd13, r); chk("R11 cap ptr", r, 32'h40);
    rd(6'd16, r); chk("R11 pm cap", r, 32'h0002_4801);
    rd(6'd18, r); chk("R11 msi cap", r, 32'h0086_0005);
    rd(6'd30, r); chk("R13 empty", r, 0);

    // sizing R4 R5 R6 R7
    wr(6'd4, 4'hF, 32'hFFFF_FFFF);  rd(6'd4, r);  chk("R4 io size", r, 32'hFFFF_FF01);
    chk("R4 io base", io_base, 32'hFFFF_FF00);
    wr(6'd5, 4'hF, 32'hFFFF_FFFF);  rd(6'd5, r);  chk("R5 m0 size", r, 32'hFFFF_FC04);
    wr(6'd6, 4'hF, 32'h1234_5678);  rd(6'd6, r);  chk("R5 m0 hi", r, 32'h1234_5678);
    chk("R5 m0 base", m0_base, 64'h1234_5678_FFFF_FC00);
    wr(6'd7, 4'hF, 32'hFFFF_FFFF);  rd(6'd7, r);  chk("R6 m1 size", r, 32'hFFFF_0004);
    wr(6'd8, 4'hF, 32'h0000_0001);  chk("R6 m1 base", m1_base, 64'h0000_0001_FFFF_0000);
    wr(6'd12, 4'hF, 32'hFFFF_FFFF); rd(6'd12, r); chk("R7 rom size", r, 32'hFFFF_F801);
    for (int k = 0; k < 4; k++) sh[k] = wmask(ids[k]);

    // R3 random byte-lane writes
    for (int n = 0; n < 60; n++) begin
      int s = $urandom_range(0, 3);
      logic [3:0]  b = 4'($urandom);
      logic [31:0] d = $urandom;
      wr(ids[s], b, d);
      sh[s] = merge(sh[s], d, b, wmask(ids[s]));
      rd(ids[s], r);
      chk("R3 lane", r, sh[s] | tbits(ids[s]));
    end
    chk("R4 io base rand", io_base, sh[0]);
    wr(6'd4, 4'h0, 32'h0); chk("R3 be none", io_base, sh[0]);

    // R8 command
    wr(6'd1, 4'h3, 32'hFFFF_FFFF); rd(6'd1, r); chk("R8 cmd mask", r, 32'h0010_0547);
    chk("R8 enables", {io_en, mem_en, bm}, 3'b111);
    wr(6'd1, 4'h0, 32'h0); rd(6'd1, r); chk("R3 cmd be none", r, 32'h0010_0547);

    // R7 ROM decode
    wr(6'd12, 4'hF, 32'hABCD_E801); chk("R7 rom en", rom_en, 1'b1);
    chk("R7 rom base", rom_base, 32'hABCD_E800);
    wr(6'd1, 4'h1, 32'h05); chk("R7 rom needs mem", rom_en, 1'b0);

    // R9 latency timer
    pcix = 1'b1; rd(6'd3, r); chk("R9 lat pcix", r, 32'h0000_4000);
    wr(6'd3, 4'h3, 32'h0000_2008); pcix = 1'b0; rd(6'd3, r); chk("R9 lat written", r, 32'h0000_2008);

    // R10 power management
    wr(6'd1, 4'h3, 32'h0000_0007); irq = 1'b1;
    @(negedge clk); chk("R10 intx D0", intx, 1'b1);
    wr(6'd17, 4'hF, 32'hFFFF_FFFE); chk("R10 pwr D2", pwr, 2'b10);
    chk("R10 D2 quiet", {io_en, mem_en, bm, rom_en, intx}, 5'b0);
    rd(6'd1, r); chk("R10 cmd kept", r, 32'h0010_0007);
    rd(6'd17, r); chk("R10 pmcsr", r, 32'h2);
    wr(6'd17, 4'h1, 32'h0); chk("R10 D0 resume", {io_en, mem_en, bm, rom_en, intx}, 5'b11111);
    wr(6'd17, 4'h1, 32'h3); chk("R10 D3 enables", {io_en, mem_en, bm}, 3'b111);
    wr(6'd17, 4'h1, 32'h0);
    wr(6'd1, 4'h2, 32'h0000_0400); chk("R10 intx disable", intx, 1'b0);
    wr(6'd1, 4'h2, 32'h0); chk("R10 intx back", intx, 1'b1);

    // R12 R13 MSI
    wr(6'd18, 4'h4, 32'h0071_0000); rd(6'd18, r); chk("R12 clamp", r, 32'h00B7_0005);
    chk("R13 msi en", {msi_en, intx}, 2'b10);
    wr(6'd18, 4'h4, 32'h0021_0000); rd(6'd18, r); chk("R12 mme 2", r, 32'h00A7_0005);
    wr(6'd19, 4'hF, 32'hFFFF_FFFF); rd(6'd19, r); chk("R13 addr lo", r, 32'hFFFF_FFFC);
    wr(6'd20, 4'hF, 32'h1234_5678); wr(6'd21, 4'hF, 32'hCAFE_BEEF);
    rd(6'd21, r); chk("R13 data", r, 32'h0000_BEEF);
    chk("R13 addr out", msi_addr, 64'h1234_5678_FFFF_FFFC);
    chk("R13 data out", msi_data, 16'hBEEF);
    wr(6'd18, 4'h4, 32'h0); chk("R13 msi off", {msi_en, intx}, 2'b01);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule